// File: doc/BRIEF.md
# Watchdog Timer with Encoded Timeout

This block is a watchdog timer that software arms with one control byte. The byte packs a 2-bit resolution field, a 5-bit multiplier and a steering bit. The timeout, counted in ticks of a 1/16-second enable, is `multiplier * 4^resolution`. Software writes or reads the control byte to restart the countdown. If the count runs out first, the block latches an expiry flag in a read-only status byte. It then does one of two things, chosen by the steering bit:
- It requests a system reset. In this mode it also clears its own control byte and tells a neighbouring calendar register to drop one bit.
- It gives a one-clock interrupt pulse.

A small state machine drives the timer. It has three states:
- `ST_OFF`: not counting.
- `ST_COUNT`: counting down on each tick.
- `ST_EXPIRED`: the interval ran out; the block waits for software.

It has four transitions:
- *arm*: any restart whose decoded interval is non-zero moves to `ST_COUNT`.
- *disarm*: any restart whose decoded interval is zero moves to `ST_OFF`.
- *decrement*: a tick in `ST_COUNT` with more than one tick left stays in `ST_COUNT`.
- *expire*: a tick in `ST_COUNT` with exactly one tick left moves to `ST_EXPIRED`.

A restart is a control write or a control read. It is legal from every state.

Top module: `wdog_timer`

## Requirements
- R1: Control byte fields are resolution = bits [1:0], multiplier = bits [6:2] and steering = bit 7. After a restart the block expires on exactly the `multiplier << (2*resolution)`-th tick. Ticks are counted only in cycles with no restart.
- R2: A control write stores the byte and returns it on `ctrl_rdata` from the next cycle. It also clears the expiry flag and restarts the countdown with the new byte.
- R3: A control read restarts the countdown with the stored byte. It does not change the stored byte.
- R4: On expiry the flag is set. A status read returns `{flag, 7'b0}` on `status_rdata` one cycle after the strobe, so bit 7 is the flag and bits 6:0 are zero. The flag stays set until the next control write.
- R5: On expiry with steering = 1, `rst_req` and `cent_clr` each pulse high for exactly one clock, together. The control byte reads 0x00 from that same cycle.
- R6: On expiry with steering = 0, `irq` pulses high for exactly one clock. `rst_req` and `cent_clr` stay low and the control byte is kept.
- R7: Status writes (`stat_wr`) have no effect on any output or on later status reads.
- R8: A multiplier of zero disables the timer: no expiry occurs for any number of ticks.
- R9: After an expiry the countdown stops. No further expiry occurs until a restart.
- R10: After reset all outputs are 0 and the timer is off. If a control write and a final tick fall in the same cycle, the write wins and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable every 1/16 second |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rd | input | 1 | Control byte read strobe (restarts countdown) |
| ctrl_rdata | output | 8 | Stored control byte |
| stat_wr | input | 1 | Status byte write strobe (ignored) |
| stat_wdata | input | 8 | Status byte write data (ignored) |
| stat_rd | input | 1 | Status byte read strobe |
| status_rdata | output | 8 | Status byte captured on the last read |
| rst_req | output | 1 | System reset request pulse |
| cent_clr | output | 1 | Pulse telling the calendar register to clear its bit 6 |
| irq | output | 1 | Interrupt pulse |

## Verification
Every cycle, the assertions check the following:
- each pulse output lasts a single clock;
- the reset request and the interrupt are never high together;
- the calendar clear always travels with the reset request;
- the control byte reads zero whenever a reset request is high;
- a control write always leaves the expiry flag clear;
- the flag is always set while any expiry pulse is out.

Only the bench's scenarios can show the parts that depend on history:
- the exact tick on which expiry lands for a given encoding;
- that a read restarts the interval;
- that a zero multiplier never expires;
- that the timer stays silent after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Field widths of the control byte
    localparam int RES_W  = 2;
    localparam int MULT_W = 5;
    localparam int CTRL_W = RES_W + MULT_W + 1;
    // Largest shift is 2*(2^RES_W - 1)
    localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_load.sv
module wdog_load
    import wdog_pkg::*;
#(
    parameter int P_RES_W  = RES_W,
    parameter int P_MULT_W = MULT_W,
    parameter int P_CNT_W  = CNT_W
) (
    input  logic [P_RES_W-1:0]  res,
    input  logic [P_MULT_W-1:0] mult,
    output logic [P_CNT_W-1:0]  load_val,
    output logic                load_zero
);

    localparam int SH_W = P_RES_W + 1;

    logic [SH_W-1:0] shift_amt;

    always_comb begin
        shift_amt = {res, 1'b0};
        load_val  = P_CNT_W'(mult) << shift_amt;
        load_zero = (mult == '0);
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               restart,
    input  logic [P_CNT_W-1:0] load_val,
    input  logic               load_zero,
    output logic               fire
);

    wd_state_e          state_q, state_d;
    logic [P_CNT_W-1:0] cnt_q, cnt_d;
    logic               last_tick;

    assign last_tick = (cnt_q == P_CNT_W'(1));

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            cnt_d   = load_val;
            state_d = load_zero ? ST_OFF : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_OFF;
                end
                ST_COUNT: begin
                    if (tick) begin
                        if (last_tick) begin
                            state_d = ST_EXPIRED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - P_CNT_W'(1);
                        end
                    end
                end
                ST_EXPIRED: begin
                    state_d = ST_EXPIRED;
                end
                default: begin
                    state_d = ST_OFF;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // expiry strobe
    always_comb begin
        fire = (state_q == ST_COUNT) && tick && !restart && last_tick;
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int P_RES_W  = RES_W,
    parameter int P_MULT_W = MULT_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick,
    input  logic                             ctrl_wr,
    input  logic [P_RES_W+P_MULT_W:0]        ctrl_wdata,
    input  logic                             ctrl_rd,
    output logic [P_RES_W+P_MULT_W:0]        ctrl_rdata,
    input  logic                             stat_wr,
    input  logic [P_RES_W+P_MULT_W:0]        stat_wdata,
    input  logic                             stat_rd,
    output logic [P_RES_W+P_MULT_W:0]        status_rdata,
    output logic                             rst_req,
    output logic                             cent_clr,
    output logic                             irq
);

    localparam int BYTE_W  = P_RES_W + P_MULT_W + 1;
    localparam int STEER_B = BYTE_W - 1;
    localparam int LCNT_W  = P_MULT_W + 2 * ((1 << P_RES_W) - 1);

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] ctrl_src;
    logic [BYTE_W-1:0] stat_q;
    logic              flag_q;
    logic              restart;
    logic              fire;
    logic [LCNT_W-1:0] load_val;
    logic              load_zero;
    logic              unused_stat;

    // status writes land nowhere
    assign unused_stat = stat_wr ^ (^stat_wdata);

    assign restart  = ctrl_wr | ctrl_rd;
    assign ctrl_src = ctrl_wr ? ctrl_wdata : ctrl_q;

    wdog_load #(
        .P_RES_W (P_RES_W),
        .P_MULT_W(P_MULT_W),
        .P_CNT_W (LCNT_W)
    ) u_load (
        .res      (ctrl_src[P_RES_W-1:0]),
        .mult     (ctrl_src[P_RES_W+P_MULT_W-1:P_RES_W]),
        .load_val (load_val),
        .load_zero(load_zero)
    );

    wdog_fsm #(
        .P_CNT_W(LCNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .load_val (load_val),
        .load_zero(load_zero),
        .fire     (fire)
    );

    // control byte and expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_wdata;
                flag_q <= 1'b0;
            end else if (fire) begin
                flag_q <= 1'b1;
                if (ctrl_q[STEER_B]) begin
                    ctrl_q <= '0;
                end
            end
        end
    end

    // status capture on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (stat_rd) begin
            stat_q <= {flag_q, {(BYTE_W-1){1'b0}}};
        end
    end

    // output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            cent_clr <= 1'b0;
            irq      <= 1'b0;
        end else begin
            rst_req  <= fire & ctrl_q[STEER_B];
            cent_clr <= fire & ctrl_q[STEER_B];
            irq      <= fire & ~ctrl_q[STEER_B];
        end
    end

    assign ctrl_rdata   = ctrl_q;
    assign status_rdata = stat_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic       stat_wr,
    input logic       stat_rd,
    input logic       rst_req,
    input logic       cent_clr,
    input logic       irq,
    input logic [7:0] ctrl_rdata,
    input logic [7:0] status_rdata,
    input logic       flag_q
);

    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    p_cent_with_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req == cent_clr);

    p_ctrl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (ctrl_rdata == 8'h00));

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    p_wr_clears_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !flag_q);

    p_flag_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || rst_req) |-> flag_q);

    p_stat_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_rd) |=> $stable(status_rdata));

endmodule

bind wdog_timer wdog_timer_chk u_chk (.*);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       ctrl_rd = 1'b0;
    logic [7:0] ctrl_rdata;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic [7:0] status_rdata;
    logic       rst_req, cent_clr, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int irq_seen = 0;
    int rst_seen = 0;

    always #10 clk = ~clk;

    wdog_timer u_wdog_timer (.*);

    // behavioural reference model
    int       m_ctrl, m_flag, m_cnt, m_mode, m_stat;
    int       m_rst, m_irq, m_cen;

    function automatic void m_load(int v);
        int n;
        n = (1 << (2 * (v % 4))) * ((v / 4) % 32);
        if (n == 0) m_mode = 0;
        else begin m_mode = 1; m_cnt = n; end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_flag = 0; m_cnt = 0; m_mode = 0; m_stat = 0;
            m_rst = 0; m_irq = 0; m_cen = 0;
        end else begin
            bit f;
            f = 0;
            m_rst = 0; m_irq = 0; m_cen = 0;
            if (stat_rd) m_stat = m_flag ? 128 : 0;
            if (ctrl_wr) begin
                m_ctrl = ctrl_wdata; m_flag = 0; m_load(m_ctrl);
            end else if (ctrl_rd) begin
                m_load(m_ctrl);
            end else if (m_mode == 1 && tick) begin
                if (m_cnt == 1) f = 1;
                else m_cnt = m_cnt - 1;
            end
            if (f) begin
                m_flag = 1; m_mode = 2;
                if (m_ctrl >= 128) begin m_rst = 1; m_cen = 1; m_ctrl = 0; end
                else m_irq = 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare every cycle against the model
    task automatic compare_all();
        chk("R5 rst_req", rst_req, m_rst);
        chk("R5 cent_clr", cent_clr, m_cen);
        chk("R6 irq", irq, m_irq);
        chk("R2 ctrl_rdata", ctrl_rdata, m_ctrl);
        chk("R4 status_rdata", status_rdata, m_stat);
        if (irq) irq_seen++;
        if (rst_req) rst_seen++;
    endtask

    task automatic drv(bit t, bit w = 0, logic [7:0] wd = 0, bit r = 0,
                       bit sr = 0, bit sw = 0, logic [7:0] swd = 0);
        @(negedge clk);
        if (rst_n) compare_all();
        tick = t; ctrl_wr = w; ctrl_wdata = wd; ctrl_rd = r;
        stat_rd = sr; stat_wr = sw; stat_wdata = swd;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            drv(1);
            drv(0);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R10 watchdog expired actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drv(0);
        // R10: reset state
        chk("R10 reset rst_req", rst_req, 0);
        chk("R10 reset irq", irq, 0);
        chk("R10 reset ctrl", ctrl_rdata, 0);
        chk("R10 reset status", status_rdata, 0);
        ticks(10);
        chk("R10 off no expiry", irq_seen + rst_seen, 0);

        // R1/R6: res=1 mult=1 -> 4 ticks, interrupt mode
        drv(0, 1, 8'h05);
        ticks(3);
        chk("R1 no expiry before 4th tick", irq_seen, 0);
        ticks(1);
        drv(0);
        chk("R1 R6 irq after 4th tick", irq_seen, 1);
        chk("R6 ctrl kept", ctrl_rdata, 8'h05);
        drv(0, 0, 0, 0, 1);
        drv(0);
        chk("R4 status flag", status_rdata, 8'h80);
        // R9: stays silent
        ticks(20);
        chk("R9 no second expiry", irq_seen, 1);
        // R7: status write ignored
        drv(0, 0, 0, 0, 0, 1, 8'h00);
        drv(0, 0, 0, 0, 1);
        drv(0);
        chk("R7 status write ignored", status_rdata, 8'h80);

        // R2/R5: reset mode, res=0 mult=3 -> 3 ticks
        drv(0, 1, 8'h8C);
        drv(0, 0, 0, 0, 1);
        drv(0);
        chk("R2 write clears flag", status_rdata, 8'h00);
        chk("R2 ctrl readback", ctrl_rdata, 8'h8C);
        ticks(3);
        drv(0);
        chk("R5 reset pulse once", rst_seen, 1);
        chk("R5 ctrl cleared", ctrl_rdata, 8'h00);
        chk("R5 no irq", irq_seen, 1);

        // R3: read restarts; res=0 mult=5 -> 5 ticks
        drv(0, 1, 8'h14);
        ticks(4);
        drv(0, 0, 0, 1);
        ticks(4);
        chk("R3 read restart delays expiry", irq_seen, 1);
        ticks(1);
        drv(0);
        chk("R3 expiry after restart", irq_seen, 2);

        // R10: write collides with last tick
        drv(0, 1, 8'h04);
        drv(1, 1, 8'h04);
        drv(0);
        chk("R10 write beats tick", irq_seen, 2);
        ticks(1);
        drv(0);
        chk("R10 expiry after collision", irq_seen, 3);

        // R8: multiplier zero disables
        drv(0, 1, 8'h83);
        ticks(100);
        chk("R8 zero multiplier", irq_seen + rst_seen, 4);

        // R1: largest interval res=3 mult=31 -> 1984 ticks, tick every cycle
        drv(0, 1, 8'h7F);
        for (int i = 0; i < 1983; i++) drv(1);
        drv(0);
        chk("R1 max before", irq_seen, 3);
        drv(1);
        drv(0);
        chk("R1 max expiry", irq_seen, 4);

        drv(0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule